// File: doc/BRIEF.md
# Write Response Ordering Slave

This block is the write-side control of a simple AXI subordinate. It takes one write address and the data beats of one burst. Address and data may arrive in either order, or in the same cycle. Every accepted beat becomes one write strobe into a storage array. The first beat goes to the captured address, and each later beat goes one data word further.

Beats that arrive before their address wait in a small staging buffer. They drain into the array, in order, once the address is known. The write response is raised only after three things have happened: the address handshake, the handshake of the beat marked last, and the write of every staged beat to the array. The response then stays up until the manager takes it. One transaction is in flight at a time, and a new one starts only after the previous response has been consumed.

The response valid comes from registered completion flags alone. It never depends on the response ready, so an ordering violation or a valid/ready deadlock cannot occur on that channel.

Top module: `axi_wresp_slave`

## Requirements
- R1: While `rst_n` is low, `aw_ready`, `w_ready`, `b_valid` and `mem_we` are all 0. Any beat staged before reset is discarded. In the cycle after release, `aw_ready` and `w_ready` are 1.
- R2: `aw_ready` is 1 only while no address has been accepted for the current transaction. After an address handshake it stays 0 until the response handshake, including the whole time `b_valid` is high.
- R3: After the handshake of a beat with `w_last` = 1, `w_ready` stays 0 until the response handshake. This holds even when the address is still outstanding.
- R4: `b_valid` stays 0 until all of the following have happened: the address handshake, the handshake of the beat with `w_last` = 1, and one `mem_we` pulse for every accepted beat.
- R5: Once `b_valid` is 1 with `b_ready` 0, `b_valid` stays 1 and `b_resp` holds the OKAY code 2'b00 on every following cycle until `b_ready` is 1.
- R6: In the cycle after a response handshake, `b_valid` is 0, and `aw_ready` and `w_ready` are both 1, ready for the next transaction.
- R7: Each accepted beat produces exactly one `mem_we` pulse, in acceptance order. The beat's data appears on `mem_wdata`. Beat k (counting from 0) goes to `mem_addr` = captured address + 4·k, modulo 2^ADDR_W, for a 32-bit data width.
- R8: Beats that arrive before their address are held, up to STAGE_DEPTH of them (default 4). While the buffer is full and the address has not been accepted, `w_ready` is 0.
- R9: When `b_ready` is held at 1 before the response is ready, `b_valid` still rises and stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | ADDR_W | Byte address of the first beat |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | DATA_W | Write data beat |
| w_last | input | 1 | Marks the final beat of the burst |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | output | 2 | Response code, 2'b00 = OKAY |
| mem_we | output | 1 | Write strobe to the storage array |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The assertions assume that the manager follows the handshake rules on the address and data channels. Valid and payload must be held until accepted. Exactly one beat per burst must carry `w_last`. Bursts must be no longer than MAX_BEATS. The bench drives each channel from its own counters. It raises valid only when it has a beat or address to offer, keeps the payload fixed until the cycle in which it observes ready, and marks only the final beat as last. Its vectors cover the address arriving first, in the same cycle as a beat, in the middle of a burst, after the last beat, and after the staging buffer has filled. Response ready is either held high in advance or withheld for several cycles.

// File: rtl/axi_wresp_pkg.sv
`timescale 1ns/1ps
package axi_wresp_pkg;
    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01,
        RESP_SLVERR = 2'b10,
        RESP_DECERR = 2'b11
    } bresp_e;
endpackage

// File: rtl/wbeat_stage.sv
`timescale 1ns/1ps
// Staging buffer for write beats accepted ahead of (or alongside) the address.
module wbeat_stage #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] slot;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } stage_t;

    stage_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.slot[st_q.wp] = push_data;
            st_d.wp            = bump(st_q.wp);
        end
        if (pop) begin
            st_d.rp = bump(st_q.rp);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.slot[st_q.rp];
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    // R8: the writer never pushes into a full buffer
    assert_stage_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7: a write strobe is only issued from a held beat
    assert_stage_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wr_addr_seq.sv
`timescale 1ns/1ps
// Beat address generator: base captured on the address handshake, one step per write.
module wr_addr_seq #(
    parameter int AW        = 16,
    parameter int STEP      = 4,
    parameter int MAX_BEATS = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic          clear,
    output logic [AW-1:0] addr
);
    localparam int IW = $clog2(MAX_BEATS) + 1;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [IW-1:0] idx;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        if (load) begin
            sq_d.base = load_addr;
            sq_d.idx  = '0;
        end else if (clear) begin
            sq_d.idx = '0;
        end else if (step) begin
            sq_d.idx = sq_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign addr = sq_q.base + AW'(sq_q.idx) * AW'(STEP);

    // R7: each write moves the array address one data word forward
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !load) |=> (addr == $past(addr) + AW'(STEP)));
endmodule

// File: rtl/axi_wresp_slave.sv
`timescale 1ns/1ps
module axi_wresp_slave #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int STAGE_DEPTH = 4,
    parameter int MAX_BEATS   = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic              w_last,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [1:0]        b_resp,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    import axi_wresp_pkg::*;

    localparam int BYTES = DATA_W / 8;

    typedef struct packed {
        logic   aw_done;
        logic   w_done;
        logic   b_valid;
        bresp_e resp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic aw_hs, w_hs, b_hs;
    logic stg_full, stg_empty, stg_pop;

    assign aw_ready = rst_n && !ctl_q.aw_done;
    assign w_ready  = rst_n && !ctl_q.w_done && !stg_full;
    assign aw_hs    = aw_valid && aw_ready;
    assign w_hs     = w_valid && w_ready;
    assign b_hs     = ctl_q.b_valid && b_ready;
    assign stg_pop  = ctl_q.aw_done && !stg_empty;

    always_comb begin
        ctl_d = ctl_q;
        if (aw_hs)         ctl_d.aw_done = 1'b1;
        if (w_hs && w_last) ctl_d.w_done = 1'b1;
        if (ctl_q.b_valid) begin
            ctl_d.b_valid = !b_ready;
        end else begin
            ctl_d.b_valid = ctl_q.aw_done && ctl_q.w_done && stg_empty;
            ctl_d.resp    = RESP_OKAY;
        end
        if (b_hs) begin
            ctl_d.aw_done = 1'b0;
            ctl_d.w_done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{aw_done: 1'b0, w_done: 1'b0, b_valid: 1'b0, resp: RESP_OKAY};
        else        ctl_q <= ctl_d;
    end

    wbeat_stage #(
        .DW    (DATA_W),
        .DEPTH (STAGE_DEPTH)
    ) i_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (w_hs),
        .push_data (w_data),
        .pop       (stg_pop),
        .head      (mem_wdata),
        .full      (stg_full),
        .empty     (stg_empty)
    );

    wr_addr_seq #(
        .AW        (ADDR_W),
        .STEP      (BYTES),
        .MAX_BEATS (MAX_BEATS)
    ) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (aw_hs),
        .load_addr (aw_addr),
        .step      (stg_pop),
        .clear     (b_hs),
        .addr      (mem_addr)
    );

    assign mem_we  = stg_pop;
    assign b_valid = ctl_q.b_valid;
    assign b_resp  = ctl_q.resp;

    // R2: a single address per transaction
    assert_aw_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        aw_hs |=> !aw_ready);
    // R3: no beats after the last one until the response is taken
    assert_w_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_hs && w_last) |=> !w_ready);
    // R4: response only after address, last beat and all array writes
    assert_b_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_valid) |-> (ctl_q.aw_done && ctl_q.w_done && stg_empty && !mem_we));
    // R5: response held under backpressure
    assert_b_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && b_resp == $past(b_resp)));
    // R6: response drops and channels reopen after the handshake
    assert_b_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_ready) |=> (!b_valid && aw_ready && w_ready));
endmodule

// File: tb/test_axi_wresp_slave.sv
`timescale 1ns/1ps
module test_axi_wresp_slave;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam int NV = 7;
    // per vector: base address, beat count, beats sent before address, response wait (0 = ready held high)
    localparam int VEC_ADDR  [NV] = '{'h0100, 'h0200, 'h0300, 'h0400, 'h1000, 'hFFF8, 'h0040};
    localparam int VEC_BEATS [NV] = '{1, 4, 3, 2, 8, 3, 6};
    localparam int VEC_AFTER [NV] = '{0, 0, 2, 2, 0, 1, 4};
    localparam int VEC_BWAIT [NV] = '{0, 2, 1, 3, 0, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic aw_valid = 1'b0, aw_ready;
    logic [AW-1:0] aw_addr = '0;
    logic w_valid = 1'b0, w_ready, w_last = 1'b0;
    logic [DW-1:0] w_data = '0;
    logic b_valid, b_ready = 1'b0;
    logic [1:0] b_resp;
    logic mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int checks = 0, errors = 0;
    int exp_n = 0, got_n = 0;
    logic [AW-1:0] exp_addr [16];
    logic [DW-1:0] exp_data [16];
    bit done = 1'b0;

    always #10 clk = ~clk;

    axi_wresp_slave i_axi_wresp_slave (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // array write monitor (R7)
    initial forever begin
        @(negedge clk);
        if (rst_n === 1'b1 && mem_we === 1'b1) begin
            if (got_n >= exp_n) begin
                chk(1'b0, "R7", "extra write at address", 32'(mem_addr), 32'(exp_n));
            end else begin
                chk(mem_addr == exp_addr[got_n], "R7", "write address", 32'(mem_addr), 32'(exp_addr[got_n]));
                chk(mem_wdata == exp_data[got_n], "R7", "write data", mem_wdata, exp_data[got_n]);
            end
            got_n++;
        end
    end

    task automatic run_txn(input int v);
        int n, aft, bw, sent, wait_n;
        bit aw_sent, acc_aw, acc_w;
        logic [AW-1:0] base;
        base = AW'(VEC_ADDR[v]);
        n    = VEC_BEATS[v];
        aft  = VEC_AFTER[v];
        bw   = VEC_BWAIT[v];
        for (int k = 0; k < n; k++) begin
            exp_addr[k] = AW'(VEC_ADDR[v] + 4 * k);
            exp_data[k] = 32'hA000_0000 + 32'(v * 256 + k);
        end
        got_n = 0;
        exp_n = n;
        b_ready = (bw == 0);
        sent = 0;
        aw_sent = 1'b0;
        while (sent < n || !aw_sent) begin
            @(negedge clk); #2;
            aw_valid = !aw_sent && sent >= aft;
            aw_addr  = base;
            w_valid  = sent < n;
            w_data   = 32'hA000_0000 + 32'(v * 256 + sent);
            w_last   = (sent == n - 1);
            #2;
            chk(!b_valid, "R4", "response before completion", 32'(b_valid), 0);
            if (sent == n && !aw_sent)
                chk(!w_ready, "R3", "data ready after last beat", 32'(w_ready), 0);
            if (aw_sent)
                chk(!aw_ready, "R2", "address ready after address taken", 32'(aw_ready), 0);
            if (!aw_sent && sent >= DEPTH)
                chk(!w_ready, "R8", "data ready with buffer full", 32'(w_ready), 0);
            acc_aw = aw_valid && aw_ready;
            acc_w  = w_valid && w_ready;
            @(posedge clk);
            if (acc_aw) aw_sent = 1'b1;
            if (acc_w)  sent++;
        end
        @(negedge clk); #2;
        aw_valid = 1'b0;
        w_valid  = 1'b0;
        w_last   = 1'b0;
        wait_n = 0;
        do begin
            @(negedge clk); #4;
            wait_n++;
        end while (!b_valid && wait_n < 40);
        chk(b_valid, "R4", "response raised", 32'(b_valid), 1);
        chk(got_n == n, "R4", "writes done before response", 32'(got_n), 32'(n));
        chk(!aw_ready && !w_ready, "R2", "ready while response pending", {aw_ready, w_ready}, 0);
        chk(b_resp == 2'b00, "R5", "response code", 32'(b_resp), 0);
        for (int c = 0; c < bw; c++) begin
            @(negedge clk); #4;
            chk(b_valid, "R5", "response held", 32'(b_valid), 1);
            chk(b_resp == 2'b00, "R5", "response code held", 32'(b_resp), 0);
        end
        b_ready = 1'b1;
        @(negedge clk); #4;
        if (bw == 0) chk(!b_valid, "R9", "response lasted one cycle", 32'(b_valid), 0);
        else         chk(!b_valid, "R6", "response dropped", 32'(b_valid), 0);
        chk(aw_ready && w_ready, "R6", "channels reopened", {aw_ready, w_ready}, 2'b11);
        b_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #4;
        chk(!aw_ready, "R1", "aw_ready in reset", 32'(aw_ready), 0);
        chk(!w_ready, "R1", "w_ready in reset", 32'(w_ready), 0);
        chk(!b_valid, "R1", "b_valid in reset", 32'(b_valid), 0);
        chk(!mem_we, "R1", "mem_we in reset", 32'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk); #4;
        chk(aw_ready && w_ready, "R1", "ready after release", {aw_ready, w_ready}, 2'b11);

        for (int v = 0; v < NV; v++) run_txn(v);

        // stage one beat with no address, then reset: it must never be written
        exp_n = 0;
        got_n = 0;
        @(negedge clk); #2;
        w_valid = 1'b1;
        w_data  = 32'hDEAD_BEEF;
        w_last  = 1'b0;
        @(negedge clk); #2;
        w_valid = 1'b0;
        rst_n = 1'b0;
        #2;
        chk(!aw_ready && !w_ready, "R1", "ready during mid-run reset", {aw_ready, w_ready}, 0);
        chk(!b_valid && !mem_we, "R1", "outputs during mid-run reset", {b_valid, mem_we}, 0);
        @(negedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk); #4;
        chk(aw_ready && w_ready, "R1", "ready after mid-run reset", {aw_ready, w_ready}, 2'b11);
        run_txn(1);
        run_txn(4);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule